// File: doc/BRIEF.md
# Radio Event Timer with Extended Count

This block keeps a long-running time base for radio scheduling. Time is split in two parts: a low counter that steps once per clock and folds back to zero at a programmable period, and a high overflow count that advances by one each time the low counter folds. Together they form one combined time value (16 + 24 = 40 bits by default). Software reaches everything through a simple register port. A coherent read of the combined value is taken by reading the low half first and then the high half.

Two compare units watch the low counter and two watch the overflow count. Each produces a one-cycle pulse at the exact moment its value is reached, for use as a receive or transmit start strobe. Each pulse also sets a sticky flag, and a mask selects which flags drive the interrupt line. Two event inputs, a frame-delimiter event and an end-of-transmission event, copy the combined time into a capture register and record which event caused the copy.

A two-state machine governs the coherent read. In state LIVE, a high-half read returns the running overflow count. A low-half read in LIVE snapshots the overflow count and moves to HELD. In HELD, a high-half read returns the snapshot and moves back to LIVE. A further low-half read in HELD takes a fresh snapshot and stays in HELD.

Top module: `rtmr_top`

## Requirements
- R1: While reset is asserted, the counter, overflow count, capture value, capture source, flags, mask and compare values read as zero. The period reads as PERIOD_RST (default 0). All match outputs and irq are low.
- R2: The low counter steps by one per clock. When it is at or above period−1 it returns to 0 and the overflow count rises by one at the same edge. Period 0 means a full 2^CNT_W range. The period lives at address 0, the counter at address 1 and the overflow count at address 2. Writing a period below the present count makes the counter fold at the next edge after the write takes effect.
- R3: The overflow count wraps to zero after its all-ones value (modulo 2^OVF_W).
- R4: A read of address 1 snapshots the overflow count at that clock edge, and the next read of address 2 returns that snapshot. A read of address 2 without a pending snapshot returns the live overflow count.
- R5: cnt_match[k] is high for exactly the one cycle in which the counter has stepped to the value at address 6+k.
- R6: ovf_match[k] is high for exactly the one cycle in which the overflow count has stepped to the value at address 8+k.
- R7: Each match pulse sets a sticky flag at address 10 one edge later: bits 0 and 1 for cnt_match[0] and cnt_match[1], bits 2 and 3 for ovf_match[0] and ovf_match[1]. Writing 1 to a bit clears it.
- R8: irq is high exactly when a flag bit and the matching bit of the mask at address 11 are both set.
- R9: When frame_evt or eot_evt is high at a clock edge, the capture register takes the combined time present in that cycle. Its low part reads at address 3 and its high part at address 4.
- R10: Bit 0 of address 5 records the capture source: 0 for the frame-delimiter event, 1 for end of transmission. If both events are high at once, the frame-delimiter event wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the snapshot machine) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W (24) | Write data |
| reg_rdata | output | DATA_W (24) | Read data for reg_addr, combinational |
| frame_evt | input | 1 | Frame-delimiter event, captures time |
| eot_evt | input | 1 | End-of-transmission event, captures time |
| cnt_match | output | 2 | One-cycle pulses from the counter compares |
| ovf_match | output | 2 | One-cycle pulses from the overflow compares |
| irq | output | 1 | Masked OR of the sticky flags |

## Verification
A wrong step or fold in the low counter shows within one period. It appears as a wrong value at address 1 and as a shift in the overflow count at address 2, which the stimulus table reads after known cycle counts. A snapshot machine stuck in the wrong state returns the live overflow count instead of the held one on the first high read after the overflow count has moved. Compare and capture faults show on the very cycle of the event, as a missing or stretched match pulse, a flag or irq one edge late, or a captured time off by a cycle.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;
    localparam int ADDR_W = 4;
    localparam int NCMP   = 2;
    localparam int NFLAG  = 2 * NCMP;

    typedef enum logic [ADDR_W-1:0] {
        RA_PERIOD  = 4'd0,
        RA_TIME_LO = 4'd1,
        RA_TIME_HI = 4'd2,
        RA_CAP_LO  = 4'd3,
        RA_CAP_HI  = 4'd4,
        RA_CAP_SRC = 4'd5,
        RA_CMPC0   = 4'd6,
        RA_CMPC1   = 4'd7,
        RA_CMPO0   = 4'd8,
        RA_CMPO1   = 4'd9,
        RA_FLAGS   = 4'd10,
        RA_MASK    = 4'd11
    } reg_addr_e;

    typedef enum logic { SNAP_LIVE, SNAP_HELD } snap_state_e;

    typedef enum logic { SRC_FRAME = 1'b0, SRC_EOT = 1'b1 } cap_src_e;
endpackage

// File: rtl/rtmr_base.sv
`timescale 1ns/1ps
module rtmr_base #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [OVF_W-1:0] ovf_q,
    output logic [OVF_W-1:0] ovf_nxt,
    output logic             wrap
);
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim     = period - CNT_W'(1);
        wrap    = (cnt_q >= lim);
        cnt_nxt = wrap ? '0 : cnt_q + CNT_W'(1);
        ovf_nxt = wrap ? ovf_q + OVF_W'(1) : ovf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            ovf_q <= ovf_nxt;
        end
    end
endmodule

// File: rtl/rtmr_match.sv
`timescale 1ns/1ps
module rtmr_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] nxt,
    input  logic [W-1:0] ref_val,
    output logic         hit_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= step && (nxt == ref_val);
    end
endmodule

// File: rtl/rtmr_capture.sv
`timescale 1ns/1ps
module rtmr_capture
    import rtmr_pkg::*;
#(
    parameter int TIME_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_evt,
    input  logic              eot_evt,
    input  logic [TIME_W-1:0] time_now,
    output logic [TIME_W-1:0] cap_q,
    output cap_src_e          src_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            src_q <= SRC_FRAME;
        end else if (frame_evt || eot_evt) begin
            cap_q <= time_now;
            src_q <= frame_evt ? SRC_FRAME : SRC_EOT;
        end
    end
endmodule

// File: rtl/rtmr_top.sv
`timescale 1ns/1ps
module rtmr_top
    import rtmr_pkg::*;
#(
    parameter int          CNT_W      = 16,
    parameter int          OVF_W      = 24,
    parameter int          DATA_W     = (OVF_W > CNT_W) ? OVF_W : CNT_W,
    parameter int unsigned PERIOD_RST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_evt,
    input  logic              eot_evt,
    output logic [NCMP-1:0]   cnt_match,
    output logic [NCMP-1:0]   ovf_match,
    output logic              irq
);
    localparam int TIME_W = CNT_W + OVF_W;

    logic [CNT_W-1:0]            period_q;
    logic [CNT_W-1:0]            cnt_q, cnt_nxt;
    logic [OVF_W-1:0]            ovf_q, ovf_nxt;
    logic                        wrap;
    logic [NCMP-1:0][CNT_W-1:0]  cmpc_q;
    logic [NCMP-1:0][OVF_W-1:0]  cmpo_q;
    logic [NFLAG-1:0]            flags_q, mask_q, flag_clr;
    logic [TIME_W-1:0]           cap_q;
    cap_src_e                    cap_src;
    snap_state_e                 state_q, state_nxt;
    logic [OVF_W-1:0]            hi_snap_q, hi_view;
    logic                        rd_lo, rd_hi, snap_load;

    rtmr_base #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_base (
        .clk(clk), .rst_n(rst_n), .period(period_q),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
        .ovf_q(ovf_q), .ovf_nxt(ovf_nxt), .wrap(wrap)
    );

    rtmr_capture #(.TIME_W(TIME_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .eot_evt(eot_evt),
        .time_now({ovf_q, cnt_q}), .cap_q(cap_q), .src_q(cap_src)
    );

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        rtmr_match #(.W(CNT_W)) u_mc (
            .clk(clk), .rst_n(rst_n), .step(1'b1), .nxt(cnt_nxt),
            .ref_val(cmpc_q[k]), .hit_q(cnt_match[k])
        );
        rtmr_match #(.W(OVF_W)) u_mo (
            .clk(clk), .rst_n(rst_n), .step(wrap), .nxt(ovf_nxt),
            .ref_val(cmpo_q[k]), .hit_q(ovf_match[k])
        );
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= CNT_W'(PERIOD_RST);
            cmpc_q   <= '0;
            cmpo_q   <= '0;
            mask_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == RA_PERIOD) period_q <= reg_wdata[CNT_W-1:0];
            if (reg_addr == RA_MASK)   mask_q   <= reg_wdata[NFLAG-1:0];
            for (int k = 0; k < NCMP; k++) begin
                if (reg_addr == ADDR_W'(RA_CMPC0 + k)) cmpc_q[k] <= reg_wdata[CNT_W-1:0];
                if (reg_addr == ADDR_W'(RA_CMPO0 + k)) cmpo_q[k] <= reg_wdata[OVF_W-1:0];
            end
        end
    end

    // Sticky flags: set by match pulses, cleared by writing ones
    assign flag_clr = (reg_wr && reg_addr == RA_FLAGS) ? reg_wdata[NFLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | {ovf_match, cnt_match};
    end

    assign irq = |(flags_q & mask_q);

    // Coherent-read state machine
    assign rd_lo = reg_rd && (reg_addr == RA_TIME_LO);
    assign rd_hi = reg_rd && (reg_addr == RA_TIME_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_LIVE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        snap_load = rd_lo;
        hi_view   = ovf_q;
        unique case (state_q)
            SNAP_LIVE: begin
                if (rd_lo) state_nxt = SNAP_HELD;
            end
            SNAP_HELD: begin
                hi_view = hi_snap_q;
                if (rd_lo)      state_nxt = SNAP_HELD;
                else if (rd_hi) state_nxt = SNAP_LIVE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_snap_q <= '0;
        else if (snap_load) hi_snap_q <= ovf_q;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_PERIOD:  reg_rdata = DATA_W'(period_q);
            RA_TIME_LO: reg_rdata = DATA_W'(cnt_q);
            RA_TIME_HI: reg_rdata = DATA_W'(hi_view);
            RA_CAP_LO:  reg_rdata = DATA_W'(cap_q[CNT_W-1:0]);
            RA_CAP_HI:  reg_rdata = DATA_W'(cap_q[TIME_W-1:CNT_W]);
            RA_CAP_SRC: reg_rdata = DATA_W'(cap_src == SRC_EOT);
            RA_CMPC0:   reg_rdata = DATA_W'(cmpc_q[0]);
            RA_CMPC1:   reg_rdata = DATA_W'(cmpc_q[1]);
            RA_CMPO0:   reg_rdata = DATA_W'(cmpo_q[0]);
            RA_CMPO1:   reg_rdata = DATA_W'(cmpo_q[1]);
            RA_FLAGS:   reg_rdata = DATA_W'(flags_q);
            RA_MASK:    reg_rdata = DATA_W'(mask_q);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtmr_chk.sv
`timescale 1ns/1ps
module rtmr_chk
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int OVF_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CNT_W-1:0]        period_q,
    input logic [CNT_W-1:0]        cnt_q,
    input logic [OVF_W-1:0]        ovf_q,
    input logic [NCMP-1:0]         cnt_match,
    input logic [NCMP-1:0]         ovf_match,
    input logic [NFLAG-1:0]        flags_q,
    input logic                    frame_evt,
    input logic                    eot_evt,
    input logic [CNT_W+OVF_W-1:0]  cap_q,
    input cap_src_e                cap_src
);
    logic [CNT_W-1:0] lim;
    assign lim = period_q - CNT_W'(1);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < lim) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) && $stable(ovf_q));

    a_r2_fold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= lim) |=> (cnt_q == '0) && (ovf_q == $past(ovf_q) + OVF_W'(1)));

    a_r3_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q >= lim) && (&ovf_q)) |=> (ovf_q == '0));

    for (genvar k = 0; k < NCMP; k++) begin : g_chk
        a_r5_cnt_single: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_match[k] && period_q != CNT_W'(1)) |=> !cnt_match[k]);

        a_r6_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_match[k] && period_q != CNT_W'(1)) |=> !ovf_match[k]);

        a_r7_cnt_flag: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_match[k] |=> flags_q[k]);

        a_r7_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_match[k] |=> flags_q[NCMP+k]);
    end

    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_evt || eot_evt) |=> (cap_q == {$past(ovf_q), $past(cnt_q)}));

    a_r10_frame_wins: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> (cap_src == SRC_FRAME));

    a_r10_eot_src: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_evt && !frame_evt) |=> (cap_src == SRC_EOT));
endmodule

bind rtmr_top rtmr_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .period_q(period_q), .cnt_q(cnt_q), .ovf_q(ovf_q),
    .cnt_match(cnt_match), .ovf_match(ovf_match), .flags_q(flags_q),
    .frame_evt(frame_evt), .eot_evt(eot_evt), .cap_q(cap_q), .cap_src(cap_src)
);

// File: tb/test_rtmr_top.sv
`timescale 1ns/1ps
module test_rtmr_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          frame_evt = 1'b0, eot_evt = 1'b0;
    logic [1:0]    cnt_match, ovf_match;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [DW-1:0] v;

    always #10 clk = ~clk;

    rtmr_top #(.CNT_W(16), .OVF_W(8)) i_rtmr_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_evt(frame_evt), .eot_evt(eot_evt),
        .cnt_match(cnt_match), .ovf_match(ovf_match), .irq(irq)
    );

    // period, idle cycles after the period write, expected low, expected high
    localparam int unsigned VEC [7][4] = '{
        '{5, 11, 2, 2}, '{3, 8, 0, 3}, '{16, 99, 4, 6}, '{2, 0, 1, 0},
        '{7, 6, 0, 1}, '{0, 49, 50, 0}, '{2, 514, 1, 1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frame_evt = 1'b0; eot_evt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: state during reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        reg_addr = 4'd0;  #1 check("R1 period", 32'(reg_rdata), 0);
        reg_addr = 4'd1;  #1 check("R1 count", 32'(reg_rdata), 0);
        reg_addr = 4'd10; #1 check("R1 flags", 32'(reg_rdata), 0);
        reg_addr = 4'd5;  #1 check("R1 source", 32'(reg_rdata), 0);
        check("R1 outputs", {27'd0, cnt_match, ovf_match, irq}, 0);

        // R2 / R3: stimulus table
        for (int i = 0; i < 7; i++) begin
            do_reset();
            wr(4'd0, DW'(VEC[i][0]));
            wait_clk(int'(VEC[i][1]));
            rd(4'd1, v); check(i == 6 ? "R3 low" : "R2 low", 32'(v), VEC[i][2]);
            rd(4'd2, v); check(i == 6 ? "R3 high" : "R2 high", 32'(v), VEC[i][3]);
        end

        // R2: shrinking the period below the present count
        do_reset();
        wait_clk(20);
        wr(4'd0, 16'd5);
        wait_clk(1);
        rd(4'd1, v); check("R2 shrink low", 32'(v), 0);
        rd(4'd2, v); check("R2 shrink high", 32'(v), 1);

        // R4: snapshot held across overflow changes, then live again
        do_reset();
        wr(4'd0, 16'd4);
        wait_clk(5);
        rd(4'd1, v); check("R4 low", 32'(v), 2);
        wait_clk(8);
        rd(4'd2, v); check("R4 held high", 32'(v), 1);
        rd(4'd2, v); check("R4 live high", 32'(v), 4);

        // R5 / R7 / R8: counter compares, flags, mask
        do_reset();
        wr(4'd0, 16'd10);
        wr(4'd6, 16'd3);
        wr(4'd11, 16'd1);
        check("R5 pulse", 32'(cnt_match), 32'h1);
        check("R8 irq before flag", 32'(irq), 0);
        wait_clk(1);
        check("R5 single cycle", 32'(cnt_match), 0);
        check("R8 irq set", 32'(irq), 1);
        rd(4'd10, v); check("R7 flag set", 32'(v), 1);
        wr(4'd10, 16'd1);
        check("R7 irq after clear", 32'(irq), 0);
        rd(4'd10, v); check("R7 flag cleared", 32'(v), 0);
        wr(4'd11, 16'd0);
        wr(4'd7, 16'd5);
        wait_clk(6);
        check("R5 second compare", 32'(cnt_match), 32'h2);
        wait_clk(1);
        check("R8 masked irq", 32'(irq), 0);
        rd(4'd10, v); check("R7 both flags", 32'(v), 3);

        // R6: overflow compare
        do_reset();
        wr(4'd0, 16'd4);
        wr(4'd8, 16'd2);
        wr(4'd11, 16'd4);
        wait_clk(4);
        check("R6 before", 32'(ovf_match), 0);
        wait_clk(1);
        check("R6 pulse", 32'(ovf_match), 32'h1);
        check("R8 irq not yet", 32'(irq), 0);
        wait_clk(1);
        check("R6 single cycle", 32'(ovf_match), 0);
        check("R8 irq ovf flag", 32'(irq), 1);

        // R9 / R10: capture and its source
        do_reset();
        wr(4'd0, 16'd6);
        wait_clk(12);
        frame_evt = 1'b1; @(negedge clk); frame_evt = 1'b0;
        rd(4'd3, v); check("R9 cap low", 32'(v), 1);
        rd(4'd4, v); check("R9 cap high", 32'(v), 2);
        rd(4'd5, v); check("R10 frame source", 32'(v), 0);
        eot_evt = 1'b1; @(negedge clk); eot_evt = 1'b0;
        rd(4'd3, v); check("R9 eot cap low", 32'(v), 5);
        rd(4'd5, v); check("R10 eot source", 32'(v), 1);
        frame_evt = 1'b1; eot_evt = 1'b1; @(negedge clk);
        frame_evt = 1'b0; eot_evt = 1'b0;
        rd(4'd5, v); check("R10 both events", 32'(v), 0);
        rd(4'd3, v); check("R9 both cap low", 32'(v), 2);
        rd(4'd4, v); check("R9 both cap high", 32'(v), 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule